// File: doc/BRIEF.md
# Four-Function Byte Shifter

This block moves an eight-bit word by one position in one of four ways, picked by a two-bit operation code: arithmetic right shift, pass-through, left rotation and right rotation. Bit 0 is the sign (most significant) position, and "right" moves data toward higher indices. No mode ever brings in a zero at either end. Every bit of the result comes from the input word.

The result appears on a combinational output in the same cycle as the inputs. It is also captured in an output register when the caller raises a valid strobe. A one-cycle strobe marks each captured result, which makes the block easy to drop into a pipelined datapath.

Top module: `shf8_unit`

## Requirements
- R1: With op_sel = 2'b00 (arithmetic right), comb_out[0] and comb_out[1] both equal data_in[0], and comb_out[i+1] equals data_in[i] for i = 1..6.
- R2: With op_sel = 2'b01 (pass), comb_out equals data_in bit for bit.
- R3: With op_sel = 2'b10 (rotate left), comb_out[i] equals data_in[i+1] for i = 0..6, and comb_out[7] equals data_in[0].
- R4: With op_sel = 2'b11 (rotate right), comb_out[i+1] equals data_in[i] for i = 0..6, and comb_out[0] equals data_in[7].
- R5: comb_out follows data_in and op_sel with no clock edge in between.
- R6: Suppose in_valid is high at a rising edge of clk. After that edge, res_out holds the comb_out value from before the edge, and res_valid is high for that one cycle.
- R7: Suppose in_valid is low at a rising edge of clk. After that edge, res_valid is low and res_out keeps its previous value.
- R8: While rst_n is low, res_out is 8'h00 and res_valid is 0.
- R9: No mode inserts a constant. Both rotations keep the number of ones in the word, and the arithmetic shift keeps bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Capture strobe for the output register |
| data_in | input | 8 | Operand word, bit 0 is the sign position |
| op_sel | input | 2 | Operation code: 00 arithmetic right, 01 pass, 10 rotate left, 11 rotate right |
| comb_out | output | 8 | Combinational result |
| res_out | output | 8 | Registered result |
| res_valid | output | 1 | High for one cycle after each capture |

## Verification
The combinational result is due in the same cycle as the stimulus. The bench drives inputs at the falling edge and checks comb_out a nanosecond later, before any rising edge. The registered result and its strobe are due one rising edge after capture. So at the next falling edge the bench compares them with the value predicted for the earlier stimulus. Cycles with the strobe low are checked at that same point, to confirm the held value.

// File: rtl/shf8_pkg.sv
package shf8_pkg;
    localparam int unsigned WORD_W = 8;
    localparam int unsigned OP_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ASR  = 2'b00,
        OP_PASS = 2'b01,
        OP_ROL  = 2'b10,
        OP_ROR  = 2'b11
    } shf_op_e;
endpackage

// File: rtl/shf8_core.sv
module shf8_core
    import shf8_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0]    d,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    s
);
    localparam int unsigned LAST = W - 1;

    shf_op_e op_e;
    assign op_e = shf_op_e'(op);

    for (genvar i = 0; i < W; i++) begin : g_slice
        logic from_lo;   // source bit for a move toward higher index
        logic from_hi;   // source bit for a move toward lower index
        logic asr_src;

        if (i == 0) begin : g_first
            assign from_lo = d[LAST];
            assign asr_src = d[0];
        end else begin : g_mid_lo
            assign from_lo = d[i-1];
            assign asr_src = d[i-1];
        end

        if (i == LAST) begin : g_last
            assign from_hi = d[0];
        end else begin : g_mid_hi
            assign from_hi = d[i+1];
        end

        always_comb begin
            unique case (op_e)
                OP_ASR:  s[i] = asr_src;
                OP_PASS: s[i] = d[i];
                OP_ROL:  s[i] = from_hi;
                OP_ROR:  s[i] = from_lo;
                default: s[i] = d[i];
            endcase
        end
    end
endmodule

// File: rtl/shf8_stage.sv
module shf8_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         q_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) begin
                q <= d;
            end
        end
    end
endmodule

// File: rtl/shf8_unit.sv
module shf8_unit
    import shf8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] data_in,
    input  logic [OP_W-1:0]   op_sel,
    output logic [WORD_W-1:0] comb_out,
    output logic [WORD_W-1:0] res_out,
    output logic              res_valid
);
    shf8_core #(.W(WORD_W)) u_core (
        .d  (data_in),
        .op (op_sel),
        .s  (comb_out)
    );

    shf8_stage #(.W(WORD_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (comb_out),
        .q       (res_out),
        .q_valid (res_valid)
    );
endmodule

// File: rtl/shf8_unit_chk.sv
module shf8_unit_chk
    import shf8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] data_in,
    input logic [OP_W-1:0]   op_sel,
    input logic [WORD_W-1:0] comb_out,
    input logic [WORD_W-1:0] res_out,
    input logic              res_valid
);
    assert_asr_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b00) |-> (comb_out[0] == data_in[0] && comb_out[1] == data_in[0]));

    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b01) |-> (comb_out == data_in));

    assert_rol_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b10) |-> (comb_out[7] == data_in[0] && comb_out[0] == data_in[1]));

    assert_ror_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b11) |-> (comb_out[0] == data_in[7] && comb_out[7] == data_in[6]));

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_valid && res_out == $past(comb_out)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && $stable(res_out)));

    assert_no_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[1] |-> ($countones(comb_out) == $countones(data_in)));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_R8: assert (res_out == '0 && !res_valid);
        end
    end
endmodule

bind shf8_unit shf8_unit_chk u_chk (.*);

// File: tb/shf8_unit_bench.sv
module shf8_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [1:0] op_sel = 2'b00;
    logic [7:0] comb_out, res_out;
    logic       res_valid;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shf8_unit u_shf8_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_in(data_in),
        .op_sel(op_sel), .comb_out(comb_out), .res_out(res_out), .res_valid(res_valid)
    );

    function automatic logic [7:0] model(input logic [7:0] d, input logic [1:0] op);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            case (op)
                2'b00: r[i] = (i == 0) ? d[0] : d[i-1];
                2'b01: r[i] = d[i];
                2'b10: r[i] = (i == 7) ? d[0] : d[i+1];
                default: r[i] = (i == 0) ? d[7] : d[i-1];
            endcase
        end
        return r;
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [7:0] held_exp = 8'h00;
    logic       prev_v = 1'b0;

    // One cycle: check the registered result of the last stimulus, then apply a new one.
    task automatic step(input logic v, input logic [7:0] d, input logic [1:0] op);
        @(negedge clk);
        check(prev_v ? "R6" : "R7", {res_valid, res_out}, {prev_v, held_exp});
        in_valid = v;
        data_in  = d;
        op_sel   = op;
        #1;
        check({op_tag(op), "/R5"}, {1'b0, comb_out}, {1'b0, model(d, op)});
        if (op[1]) check("R9", 9'($countones(comb_out)), 9'($countones(d)));
        else if (op == 2'b00) check("R9", {8'h00, comb_out[0]}, {8'h00, d[0]});
        if (v) held_exp = model(d, op);
        prev_v = v;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        #2;
        check("R8", {res_valid, res_out}, 9'h000);
        @(negedge clk);
        check("R8", {res_valid, res_out}, 9'h000);
        rst_n = 1'b1;
        // directed corners
        step(1'b1, 8'h01, 2'b00);   // sign set: both top bits
        step(1'b1, 8'hFE, 2'b00);   // sign clear
        step(1'b1, 8'h80, 2'b11);   // D7 wraps to D0
        step(1'b1, 8'h01, 2'b10);   // D0 wraps to D7
        step(1'b1, 8'hFF, 2'b10);
        step(1'b1, 8'hFF, 2'b11);
        step(1'b1, 8'hA5, 2'b01);
        step(1'b0, 8'h3C, 2'b11);   // not captured
        step(1'b0, 8'h00, 2'b00);
        step(1'b1, 8'h00, 2'b01);
        // constrained random
        for (int n = 0; n < 400; n++) begin
            step(($urandom % 4) != 0, 8'($urandom), 2'($urandom));
        end
        step(1'b0, 8'h00, 2'b01);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule